// File: doc/BRIEF.md
# Receive Frame Status Queue

This block keeps the bookkeeping for frames that sit in a receive buffer. It does not store frame data. For every frame the MAC side opens, it holds one 16-bit status word. The word carries a still-arriving flag, an error flag, a three-bit error type and an 11-bit byte count. The MAC side marks frame boundaries and each stored byte with single-cycle strobes. At the end of a frame it hands over a four-bit error code.

The host sees only the oldest frame, through a status port. It reads that frame's data bytes one strobe at a time and drops the frame with a discard strobe. The block gives two notices. A completion level is high while a finished frame is at the head. An early-arrival pulse fires when a frame that is still arriving at the head has collected a programmable number of bytes. Four diagnostic flags report the receive state:

- a frame is being received;
- the host has read past the available data (this flag also drives adapter failure);
- the frame slots are exhausted;
- the byte space is exhausted.

An RX reset strobe empties everything.

Top module: `rx_frame_status_queue`

## Requirements
- R1: With no frame held, `rx_status` reads 0x8000. While the head frame is still arriving, bit 15 is 1, bits 14..11 are 0 and bits 10..0 give the bytes counted so far.
- R2: Once the end-of-frame strobe is taken, the head word has bit 15 at 0, bits 14..11 equal to the `mac_code` given with that strobe, and the final count in bits 10..0. Examples are CRC 4'b1101 giving 0x6800, dribble 4'b0010 giving 0x1000, and runt 4'b1011 giving 0x5800. `rx_complete` is high exactly while a finished frame is at the head.
- R3: At most DEPTH (8) frames are held. A start-of-frame strobe while DEPTH frames are held is refused and sets `diag_status_overrun`. The refused frame's bytes and end strobe are ignored, and the held frames are unchanged.
- R4: `diag_status_overrun` clears, with no other host action, on the cycle after a frame is removed.
- R5: `host_discard` removes the head frame, and frames leave in arrival order. With no frame held, a discard has no effect.
- R6: `rx_early` is a one-cycle pulse, at most once per frame. It fires when a frame that is still arriving is at the head and its count is at least `early_thresh`. A frame that finishes before it reaches the head, or before it reaches the threshold, gives no pulse.
- R7: A `host_rd` strobe when the head frame has no unread counted byte, or when the queue is empty, sets `diag_rx_underrun` and `adapter_fail`. These stay set until `host_rx_reset` or `rst_n`.
- R8: The block counts bytes held, minus bytes read and discarded. When the count reaches CAP_BYTES (2048), `diag_rx_overrun` sets. While the count is at CAP_BYTES, further bytes are not counted. While the flag is set, start-of-frame strobes are refused without setting `diag_status_overrun`. The flag clears once the count is at most CAP_BYTES - OVR_HYST (4 below).
- R9: `diag_receiving` is high from the cycle after an accepted start-of-frame strobe until the frame's end strobe, its discard, or an RX reset.
- R10: Discarding a head frame that is still arriving drops it at once. Its later byte and end strobes are ignored.
- R11: A frame's byte count stops at 2047 and does not wrap.
- R12: `host_rx_reset` empties the queue and clears `diag_status_overrun`, `diag_rx_overrun`, `diag_rx_underrun` and `diag_receiving`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (global reset) |
| mac_sof | input | 1 | Start of a new frame; taken only while no frame is arriving |
| mac_byte | input | 1 | One byte of the arriving frame stored |
| mac_eof | input | 1 | End of the arriving frame |
| mac_code | input | 4 | Error code for status bits 14..11, valid with `mac_eof` |
| host_rd | input | 1 | Host reads one data byte of the head frame |
| host_discard | input | 1 | Remove the head frame |
| host_rx_reset | input | 1 | RX reset: empty queue, clear flags |
| early_thresh | input | 11 | Byte count that triggers `rx_early` |
| rx_status | output | 16 | Status word of the head frame |
| rx_complete | output | 1 | Finished frame at the head |
| rx_early | output | 1 | Early-arrival pulse |
| adapter_fail | output | 1 | Failure indication from a read underrun |
| diag_receiving | output | 1 | A frame is being received |
| diag_rx_underrun | output | 1 | Host read past the available data |
| diag_status_overrun | output | 1 | Frame refused because all slots were in use |
| diag_rx_overrun | output | 1 | Byte space full |

## Verification
Some properties are checked on every cycle by assertions:

- the slot count never passes DEPTH;
- a removal shrinks it by one;
- the held-byte count never passes CAP_BYTES;
- the underrun flag stays set until cleared;
- the early pulse lasts one cycle;
- an empty queue always shows 0x8000 and a completed head never shows bit 15;
- the slot-overrun flag always falls after a removal.

Other behaviour can only be shown by the directed scenarios:

- the exact word values for each error code;
- FIFO order across a full queue;
- which frame is refused and which survives;
- the count at saturation and at the byte-space limit;
- the hysteresis point of the overrun flag;
- whether the early pulse is absent for frames that are too short or not at the head.

// File: rtl/rxsq_pkg.sv
// Shared constants and the per-frame record for the receive status queue.
// Assumes the 16-bit status format: [15] arriving/empty, [14:11] code, [10:0] count.
package rxsq_pkg;
    localparam int unsigned CNT_W  = 11;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned WORD_W = 16;

    typedef struct packed {
        logic              done;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  count;
    } frame_entry_t;

    localparam logic [WORD_W-1:0] EMPTY_WORD = 16'h8000;
endpackage

// File: rtl/rxsq_entry_store.sv
// Circular store of frame records with head/tail pointers and a fill level.
// Tracks the single frame that is still arriving (cur_idx). Assumes the caller
// allocates only when not full and not arriving, and pops only when not empty.
module rxsq_entry_store
    import rxsq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              alloc,
    input  logic              add_byte,
    input  logic              finish,
    input  logic [CODE_W-1:0] fin_code,
    input  logic              pop,
    output logic [LVL_W-1:0]  level,
    output frame_entry_t      head,
    output logic              in_prog,
    output logic              cur_is_head,
    output logic [CNT_W-1:0]  cur_count
);
    frame_entry_t     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] cur_idx;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        adv = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Per-slot record update: cleared on allocation, grown while arriving.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (alloc && wr_ptr == PTR_W'(g)) begin
                slot_q[g] <= '0;
            end else if (in_prog && cur_idx == PTR_W'(g)) begin
                if (add_byte && slot_q[g].count != '1)
                    slot_q[g].count <= slot_q[g].count + 1'b1;
                if (finish) begin
                    slot_q[g].done <= 1'b1;
                    slot_q[g].code <= fin_code;
                end
            end
        end
    end

    assign cur_is_head = in_prog && (cur_idx == rd_ptr) && (level != '0);
    assign head        = slot_q[rd_ptr];
    assign cur_count   = slot_q[cur_idx].count;

    // Pointer, level and arriving-frame bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cur_idx <= '0;
            level   <= '0;
            in_prog <= 1'b0;
        end else begin
            if (alloc) begin
                wr_ptr  <= adv(wr_ptr);
                cur_idx <= wr_ptr;
            end
            if (pop)
                rd_ptr <= adv(rd_ptr);
            level <= level + LVL_W'(alloc) - LVL_W'(pop);
            if (alloc)
                in_prog <= 1'b1;
            else if (finish || (pop && cur_is_head))
                in_prog <= 1'b0;
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    a_r3_alloc_room: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (level != LVL_W'(DEPTH)));

    a_r5_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !alloc && !clr) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/rxsq_byte_space.sv
// Counts bytes held in the receive buffer and raises the byte-space overrun
// flag with hysteresis. Assumes drop_cnt never exceeds the bytes held.
module rxsq_byte_space #(
    parameter int unsigned CAP_BYTES = 2048,
    parameter int unsigned OVR_HYST  = 4,
    localparam int unsigned OCC_W    = $clog2(CAP_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_in,
    input  logic             byte_out,
    input  logic [OCC_W-1:0] drop_cnt,
    output logic             space_full,
    output logic             rx_ovr
);
    logic [OCC_W-1:0] occ;
    logic [OCC_W:0]   sum;
    logic [OCC_W-1:0] occ_nxt;

    // Next occupancy after this cycle's arrivals, reads and discards.
    always_comb begin
        sum     = {1'b0, occ} + (OCC_W+1)'(byte_in) - (OCC_W+1)'(byte_out)
                  - {1'b0, drop_cnt};
        occ_nxt = sum[OCC_W-1:0];
    end

    assign space_full = (occ == OCC_W'(CAP_BYTES));

    // Occupancy register and overrun flag with release hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            occ    <= '0;
            rx_ovr <= 1'b0;
        end else begin
            occ <= occ_nxt;
            if (occ_nxt >= OCC_W'(CAP_BYTES))
                rx_ovr <= 1'b1;
            else if (occ_nxt <= OCC_W'(CAP_BYTES - OVR_HYST))
                rx_ovr <= 1'b0;
        end
    end

    a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(CAP_BYTES));
endmodule

// File: rtl/rxsq_head_mon.sv
// Watches the head frame: counts host data reads, flags reads past the
// counted bytes, and produces the once-per-frame early-arrival pulse.
// Assumes pop and alloc come from the same cycle decisions as the store.
module rxsq_head_mon
    import rxsq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             head_valid,
    input  logic [CNT_W-1:0] head_count,
    input  logic             rd_req,
    input  logic             pop,
    input  logic             alloc,
    input  logic             in_prog,
    input  logic             cur_is_head,
    input  logic [CNT_W-1:0] cur_count,
    input  logic [CNT_W-1:0] thresh,
    output logic             rd_ok,
    output logic [CNT_W-1:0] remain,
    output logic             underrun,
    output logic             early
);
    logic [CNT_W-1:0] rd_cnt;
    logic             early_done;
    logic             rd_bad;

    assign rd_ok  = rd_req && !pop && head_valid && (rd_cnt < head_count);
    assign rd_bad = rd_req && !pop && !rd_ok;
    assign remain = head_count - rd_cnt;
    assign early  = in_prog && cur_is_head && !early_done && (cur_count >= thresh);

    // Bytes already read from the head frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || pop)
            rd_cnt <= '0;
        else if (rd_ok)
            rd_cnt <= rd_cnt + 1'b1;
    end

    // Sticky underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            underrun <= 1'b0;
        else if (rd_bad)
            underrun <= 1'b1;
    end

    // Marks that the arriving frame has already given its early pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || alloc)
            early_done <= 1'b0;
        else if (early)
            early_done <= 1'b1;
    end

    a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !clr) |=> underrun);

    a_r6_early_once: assert property (@(posedge clk) disable iff (!rst_n)
        early |=> !early);
endmodule

// File: rtl/rx_frame_status_queue.sv
// Top of the receive frame status queue. Decides frame acceptance, refusal,
// byte counting and removal, and forms the head status word and flags.
// Assumes the MAC brackets each frame with one start and one end strobe.
module rx_frame_status_queue
    import rxsq_pkg::*;
#(
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned CAP_BYTES = 2048,
    parameter int unsigned OVR_HYST  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_sof,
    input  logic              mac_byte,
    input  logic              mac_eof,
    input  logic [CODE_W-1:0] mac_code,
    input  logic              host_rd,
    input  logic              host_discard,
    input  logic              host_rx_reset,
    input  logic [CNT_W-1:0]  early_thresh,
    output logic [WORD_W-1:0] rx_status,
    output logic              rx_complete,
    output logic              rx_early,
    output logic              adapter_fail,
    output logic              diag_receiving,
    output logic              diag_rx_underrun,
    output logic              diag_status_overrun,
    output logic              diag_rx_overrun
);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);
    localparam int unsigned OCC_W = $clog2(CAP_BYTES + 1);

    logic [LVL_W-1:0] level;
    frame_entry_t     head;
    logic             in_prog, cur_is_head;
    logic [CNT_W-1:0] cur_count, remain;
    logic             empty, full, space_full, rx_ovr;
    logic             pop, pop_cur, accept, refuse_full, byte_ok, finish;
    logic             rd_ok, stat_ovr;

    assign empty = (level == '0);
    assign full  = (level == LVL_W'(DEPTH));

    // Per-cycle decisions on host and MAC strobes.
    always_comb begin
        pop         = host_discard && !empty && !host_rx_reset;
        pop_cur     = pop && cur_is_head;
        accept      = mac_sof && !in_prog && !full && !rx_ovr && !host_rx_reset;
        refuse_full = mac_sof && !in_prog && full && !host_rx_reset;
        byte_ok     = mac_byte && in_prog && !pop_cur && !space_full
                      && (cur_count != '1) && !host_rx_reset;
        finish      = mac_eof && in_prog && !pop_cur && !host_rx_reset;
    end

    rxsq_entry_store #(.DEPTH(DEPTH)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (host_rx_reset),
        .alloc      (accept),
        .add_byte   (byte_ok),
        .finish     (finish),
        .fin_code   (mac_code),
        .pop        (pop),
        .level      (level),
        .head       (head),
        .in_prog    (in_prog),
        .cur_is_head(cur_is_head),
        .cur_count  (cur_count)
    );

    rxsq_byte_space #(.CAP_BYTES(CAP_BYTES), .OVR_HYST(OVR_HYST)) space_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (host_rx_reset),
        .byte_in   (byte_ok),
        .byte_out  (rd_ok),
        .drop_cnt  (pop ? OCC_W'(remain) : '0),
        .space_full(space_full),
        .rx_ovr    (rx_ovr)
    );

    rxsq_head_mon head_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (host_rx_reset),
        .head_valid (!empty),
        .head_count (head.count),
        .rd_req     (host_rd && !host_rx_reset),
        .pop        (pop),
        .alloc      (accept),
        .in_prog    (in_prog),
        .cur_is_head(cur_is_head),
        .cur_count  (cur_count),
        .thresh     (early_thresh),
        .rd_ok      (rd_ok),
        .remain     (remain),
        .underrun   (diag_rx_underrun),
        .early      (rx_early)
    );

    // Slot-overrun flag: set by a refused frame, cleared by any removal.
    always_ff @(posedge clk) begin
        if (!rst_n || host_rx_reset)
            stat_ovr <= 1'b0;
        else if (pop)
            stat_ovr <= 1'b0;
        else if (refuse_full)
            stat_ovr <= 1'b1;
    end

    // Head status word formatting.
    always_comb begin
        if (empty)
            rx_status = EMPTY_WORD;
        else if (head.done)
            rx_status = {1'b0, head.code, head.count};
        else
            rx_status = {1'b1, {CODE_W{1'b0}}, head.count};
    end

    assign rx_complete         = !empty && head.done;
    assign adapter_fail        = diag_rx_underrun;
    assign diag_receiving      = in_prog;
    assign diag_status_overrun = stat_ovr;
    assign diag_rx_overrun     = rx_ovr;

    a_r1_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rx_status == EMPTY_WORD));

    a_r2_complete_word: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> !rx_status[15]);

    a_r4_stat_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !diag_status_overrun);

    a_r9_arriving_word: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_receiving && cur_is_head) |-> rx_status[15]);
endmodule

// File: tb/rx_frame_status_queue_tb_top.sv
// Directed bench for the receive frame status queue.
module rx_frame_status_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mac_sof = 0, mac_byte = 0, mac_eof = 0;
    logic [3:0]  mac_code = 4'd0;
    logic        host_rd = 0, host_discard = 0, host_rx_reset = 0;
    logic [10:0] early_thresh = 11'd64;
    logic [15:0] rx_status;
    logic        rx_complete, rx_early, adapter_fail;
    logic        diag_receiving, diag_rx_underrun, diag_status_overrun, diag_rx_overrun;

    int n_chk = 0;
    int n_bad = 0;
    int early_seen = 0;

    always #2 clk = ~clk;

    rx_frame_status_queue dut_i (
        .clk(clk), .rst_n(rst_n),
        .mac_sof(mac_sof), .mac_byte(mac_byte), .mac_eof(mac_eof), .mac_code(mac_code),
        .host_rd(host_rd), .host_discard(host_discard), .host_rx_reset(host_rx_reset),
        .early_thresh(early_thresh),
        .rx_status(rx_status), .rx_complete(rx_complete), .rx_early(rx_early),
        .adapter_fail(adapter_fail), .diag_receiving(diag_receiving),
        .diag_rx_underrun(diag_rx_underrun), .diag_status_overrun(diag_status_overrun),
        .diag_rx_overrun(diag_rx_overrun)
    );

    always @(negedge clk) if (rx_early) early_seen++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic sof();
        mac_sof = 1; @(negedge clk); mac_sof = 0;
    endtask
    task automatic bytes(input int n);
        mac_byte = 1; repeat (n) @(negedge clk); mac_byte = 0;
    endtask
    task automatic eof(input logic [3:0] c);
        mac_code = c; mac_eof = 1; @(negedge clk); mac_eof = 0; mac_code = 0;
    endtask
    task automatic frame(input int n, input logic [3:0] c);
        sof(); if (n > 0) bytes(n); eof(c);
    endtask
    task automatic discard();
        host_discard = 1; @(negedge clk); host_discard = 0;
    endtask
    task automatic rd(input int n);
        host_rd = 1; repeat (n) @(negedge clk); host_rd = 0;
    endtask
    task automatic rx_reset();
        host_rx_reset = 1; @(negedge clk); host_rx_reset = 0;
    endtask

    task automatic t_reset_state();
        check("R1 reset status", rx_status, 32'h8000);
        check("R2 reset complete", rx_complete, 0);
        check("R9 reset receiving", diag_receiving, 0);
        check("R12 reset flags", {diag_rx_underrun, diag_status_overrun, diag_rx_overrun}, 0);
    endtask

    task automatic t_single();
        sof();
        check("R9 receiving after sof", diag_receiving, 1);
        bytes(10);
        check("R1 arriving word", rx_status, 32'h800A);
        eof(4'd0);
        check("R2 finished word", rx_status, 32'h000A);
        check("R2 complete high", rx_complete, 1);
        check("R9 receiving after eof", diag_receiving, 0);
        rd(10);
        check("R7 no underrun on exact read", diag_rx_underrun, 0);
        discard();
        check("R5 empty after discard", rx_status, 32'h8000);
        check("R2 complete low", rx_complete, 0);
    endtask

    task automatic t_codes();
        frame(60, 4'b1101);
        frame(64, 4'b0010);
        frame(20, 4'b1011);
        check("R2 crc word", rx_status, 32'h683C);
        discard();
        check("R2 dribble word", rx_status, 32'h1040);
        discard();
        check("R2 runt word", rx_status, 32'h5814);
        discard();
        check("R5 drained", rx_status, 32'h8000);
    endtask

    task automatic t_discard_empty();
        discard();
        check("R5 discard empty", rx_status, 32'h8000);
        frame(5, 4'd0);
        check("R5 order kept after empty discard", rx_status, 32'h0005);
        discard();
    endtask

    task automatic t_full();
        for (int i = 1; i <= 8; i++) frame(i, 4'd0);
        check("R3 no overrun at eight", diag_status_overrun, 0);
        sof();
        check("R3 ninth refused", diag_receiving, 0);
        bytes(50); eof(4'b1101);
        check("R3 overrun flag", diag_status_overrun, 1);
        check("R3 head unchanged", rx_status, 32'h0001);
        discard();
        check("R4 overrun self-clears", diag_status_overrun, 0);
        frame(9, 4'd0);
        for (int i = 2; i <= 9; i++) begin
            check("R5 fifo order", rx_status, 32'(i));
            discard();
        end
        check("R3 refused frame absent", rx_status, 32'h8000);
    endtask

    task automatic t_early();
        early_seen = 0;
        frame(100, 4'd0);
        check("R6 one pulse long frame", early_seen, 1);
        discard();
        early_seen = 0;
        frame(30, 4'd0);
        check("R6 no pulse short frame", early_seen, 0);
        discard();
        frame(5, 4'd0);
        early_seen = 0;
        frame(100, 4'd0);
        check("R6 no pulse when not head", early_seen, 0);
        discard(); discard();
    endtask

    task automatic t_underrun();
        frame(3, 4'd0);
        rd(3);
        check("R7 no underrun yet", diag_rx_underrun, 0);
        rd(1);
        check("R7 underrun set", diag_rx_underrun, 1);
        check("R7 adapter fail", adapter_fail, 1);
        discard();
        check("R7 underrun sticky", diag_rx_underrun, 1);
        frame(4, 4'd0);
        rx_reset();
        check("R12 underrun cleared", diag_rx_underrun, 0);
        check("R12 queue emptied", rx_status, 32'h8000);
    endtask

    task automatic t_discard_arriving();
        sof(); bytes(10);
        discard();
        check("R10 arriving dropped", rx_status, 32'h8000);
        check("R10 receiving low", diag_receiving, 0);
        bytes(5); eof(4'd0);
        check("R10 tail ignored", rx_complete, 0);
        frame(7, 4'd0);
        check("R10 next frame normal", rx_status, 32'h0007);
        discard();
    endtask

    task automatic t_saturate();
        frame(2050, 4'd0);
        check("R11 count saturates", rx_status, 32'h07FF);
        discard();
    endtask

    task automatic t_overrun();
        frame(1500, 4'd0);
        sof(); bytes(547);
        check("R8 not yet overrun", diag_rx_overrun, 0);
        bytes(1);
        check("R8 overrun set", diag_rx_overrun, 1);
        bytes(3); eof(4'd0);
        frame(5, 4'd0);
        check("R8 no slot overrun", diag_status_overrun, 0);
        rd(3);
        check("R8 held within hysteresis", diag_rx_overrun, 1);
        rd(1);
        check("R8 released", diag_rx_overrun, 0);
        discard();
        check("R8 extra bytes not counted", rx_status, 32'h0224);
        discard();
        check("R8 refused frame absent", rx_status, 32'h8000);
    endtask

    task automatic t_reset_mid();
        frame(4, 4'd0);
        sof(); bytes(3);
        rx_reset();
        check("R12 receiving cleared", diag_receiving, 0);
        check("R12 empty after reset", rx_status, 32'h8000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_single();
        t_codes();
        t_discard_empty();
        t_full();
        t_early();
        t_underrun();
        t_discard_arriving();
        t_saturate();
        t_overrun();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule